// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop is in lock by timing how far apart the reference and feedback pulses of its phase detector arrive. The gap is counted in cycles of a fast sample clock. Each pair of pulses is one comparison, and each comparison ends with a good or bad verdict. The block raises a registered lock flag after a run of consecutive good verdicts. A single bad verdict clears the flag.

Two programmable counts set the limits. The acquire count applies while the flag is low. The hold count, normally about twice as large, applies while the flag is high. This hysteresis keeps a locked loop from chattering at the limit. As an example, with a 1 GHz sample clock, counts of 15 and 30 give windows of about 15 ns and 30 ns.

A comparison whose second edge is late is judged bad as soon as the count passes the limit, without waiting for that edge. A power-down input holds the flag low. When power-down is released, the detector starts again from an unlocked, empty state.

Top module: `phase_lock_judge`

## Requirements
- R1: The phase error of a comparison is the number of sample-clock cycles between the first edge of the pair and the second edge. The reference pulse and the feedback pulse may each come first. Edges that arrive in the same cycle give an error of 0.
- R2: While `lock_out` is 0, a comparison is good when its error is at most `thr_acquire`. `lock_out` rises after GOOD_RUN consecutive good comparisons (default 5) and not before.
- R3: While unlocked, a bad comparison clears the consecutive-good count to zero. GOOD_RUN new good comparisons are then needed to lock.
- R4: While `lock_out` is 1, the limit is `thr_hold`. A comparison with error at most `thr_hold` leaves `lock_out` at 1.
- R5: While locked, the first comparison whose error is greater than `thr_hold` clears `lock_out`.
- R6: A comparison is judged bad when its count passes the active limit with the second edge still absent. The judgement is made at once, without waiting for that edge. The late edge is then consumed and does not start a new comparison.
- R7: While `pwr_dn` is 1, `lock_out` is 0. After `pwr_dn` returns to 0, the detector starts unlocked with a consecutive-good count of zero.
- R8: `lock_out` changes only in the cycle after a verdict or after power-down. At all other times it holds its value.
- R9: After a synchronous active-low reset, `lock_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Loop power-down. Forces the lock flag low and clears the detector state |
| ref_pulse | input | 1 | Reference pulse from the phase detector. Its rising edge is used |
| fb_pulse | input | 1 | Feedback pulse from the phase detector. Its rising edge is used |
| thr_acquire | input | CNT_W | Error limit, in sample cycles, used while unlocked |
| thr_hold | input | CNT_W | Error limit, in sample cycles, used while locked |
| lock_out | output | 1 | Registered lock flag |

## Verification
The assertions assume the following about the inputs:
- The thresholds are static during operation.
- Each reference edge has a matching feedback edge, or is abandoned before the next reference edge arrives.

The stimulus keeps within these assumptions. It fixes the two counts at small values and sends one isolated pulse pair per comparison. Each pair is followed by an idle gap longer than the largest error plus the pipeline delay. The one exception is the missing-edge case. There the lone late edge is sent only after the verdict has been checked at the output, so the late-edge consumption rule (R6) is exercised without overlapping comparisons.

// File: rtl/ljd_pkg.sv
// Shared types for the hysteretic lock detector.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package ljd_pkg;

    // States of the phase-error meter
    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,   // waiting for the first edge of a pair
        MS_MEAS = 2'd1,   // counting until the partner edge arrives
        MS_LATE = 2'd2    // verdict already bad, partner edge still owed
    } meter_state_t;

    // One comparison outcome
    typedef struct packed {
        logic valid;
        logic good;
    } verdict_t;

endpackage

// File: rtl/ljd_edge_pick.sv
// Rising-edge picker for a group of pulse lanes.
// Registers each lane once, then flags a cycle where the registered sample
// is high and the one before it was low. Every lane has identical latency,
// so relative timing between lanes is preserved.
// Assumes pulses are at least one sample cycle wide.
module ljd_edge_pick #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pulse_in,
    output logic [LANES-1:0] rise_out
);

    logic [LANES-1:0] samp_q;
    logic [LANES-1:0] prev_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // capture the lane and its previous value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samp_q[g] <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                samp_q[g] <= pulse_in[g];
                prev_q[g] <= samp_q[g];
            end
        end

        // a rising edge is a new high following a low
        always_comb rise_out[g] = samp_q[g] & ~prev_q[g];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            rise_out[g] |=> !rise_out[g]); // R1
    end

endmodule

// File: rtl/ljd_err_meter.sv
// Phase-error meter.
// Waits for a rising edge on either lane and counts sample cycles until the
// partner lane's edge arrives. A verdict is emitted for each comparison:
// - good when the partner arrives with count <= limit;
// - bad as soon as the count reaches the limit with the partner still absent.
// After an early bad verdict, the late partner edge is consumed.
// Assumes the limit does not change while a count is running.
module ljd_err_meter
    import ljd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ref_rise,
    input  logic             fb_rise,
    input  logic [CNT_W-1:0] limit,
    output verdict_t         verdict
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    meter_state_t     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ref_first_q;
    logic             partner_rise;
    logic             lead_rise;

    // the edge that closes the pair, and the edge that opened it
    always_comb begin
        partner_rise = ref_first_q ? fb_rise  : ref_rise;
        lead_rise    = ref_first_q ? ref_rise : fb_rise;
    end

    // comparison sequencing and error counting
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state_q       <= MS_IDLE;
            cnt_q         <= '0;
            ref_first_q   <= 1'b0;
            verdict.valid <= 1'b0;
            verdict.good  <= 1'b0;
        end else begin
            verdict.valid <= 1'b0;
            verdict.good  <= 1'b0;
            unique case (state_q)
                MS_IDLE: begin
                    if (ref_rise && fb_rise) begin
                        verdict.valid <= 1'b1;
                        verdict.good  <= 1'b1;
                    end else if (ref_rise || fb_rise) begin
                        ref_first_q <= ref_rise;
                        cnt_q       <= CNT_ONE;
                        if (limit == '0) begin
                            verdict.valid <= 1'b1;
                            state_q       <= MS_LATE;
                        end else begin
                            state_q <= MS_MEAS;
                        end
                    end
                end
                MS_MEAS: begin
                    if (partner_rise) begin
                        verdict.valid <= 1'b1;
                        verdict.good  <= 1'b1;
                        state_q       <= MS_IDLE;
                    end else if (cnt_q >= limit) begin
                        verdict.valid <= 1'b1;
                        state_q       <= MS_LATE;
                    end else begin
                        cnt_q <= cnt_q + CNT_ONE;
                    end
                end
                MS_LATE: begin
                    if (partner_rise) begin
                        state_q <= MS_IDLE;
                    end else if (lead_rise) begin
                        cnt_q <= CNT_ONE;
                        if (limit == '0) begin
                            verdict.valid <= 1'b1;
                        end else begin
                            state_q <= MS_MEAS;
                        end
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_MEAS) |-> (cnt_q != '0)); // R1
    AST_VERDICT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        verdict.valid |-> (state_q != MS_MEAS)); // R6
    AST_BAD_OWES_EDGE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (verdict.valid && !verdict.good) |-> (state_q == MS_LATE)); // R6

endmodule

// File: rtl/ljd_lock_track.sv
// Lock state tracker.
// Counts consecutive good verdicts while unlocked, and locks after GOOD_RUN
// of them. Any bad verdict clears both the lock and the count. Chooses the
// active limit from the lock state: acquire limit unlocked, hold limit locked.
// Assumes verdicts are single-cycle strobes.
module ljd_lock_track
    import ljd_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int GOOD_RUN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  verdict_t         verdict,
    input  logic [CNT_W-1:0] thr_acquire,
    input  logic [CNT_W-1:0] thr_hold,
    output logic [CNT_W-1:0] limit,
    output logic             lock_q
);

    localparam int                RUN_W    = $clog2(GOOD_RUN + 1);
    localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(GOOD_RUN - 1);

    logic [RUN_W-1:0] run_q;

    // the limit follows the lock state (hysteresis)
    always_comb limit = lock_q ? thr_hold : thr_acquire;

    // run counting and lock flag update
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            lock_q <= 1'b0;
            run_q  <= '0;
        end else if (verdict.valid) begin
            if (!verdict.good) begin
                lock_q <= 1'b0;
                run_q  <= '0;
            end else if (!lock_q) begin
                if (run_q == RUN_LAST) begin
                    lock_q <= 1'b1;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + RUN_W'(1);
                end
            end
        end
    end

    AST_PWRDN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !lock_q); // R7
    AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.valid && !verdict.good) |=> !lock_q); // R5
    AST_BAD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.valid && !verdict.good) |=> (run_q == '0)); // R3
    AST_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(verdict.valid && verdict.good)); // R2
    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!verdict.valid && !pwr_dn) |=> $stable(lock_q)); // R8
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST); // R2

endmodule

// File: rtl/phase_lock_judge.sv
// Hysteretic digital lock detector, top level.
// Picks rising edges of the reference and feedback pulses, measures their
// separation in sample cycles, and turns the verdicts into a lock flag. The
// limit in use depends on the flag (acquire vs hold).
// Assumes pulses are synchronous to, or slower than, the sample clock.
module phase_lock_judge
    import ljd_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int GOOD_RUN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             ref_pulse,
    input  logic             fb_pulse,
    input  logic [CNT_W-1:0] thr_acquire,
    input  logic [CNT_W-1:0] thr_hold,
    output logic             lock_out
);

    logic [1:0]       rise;
    logic [CNT_W-1:0] limit;
    verdict_t         verdict;

    ljd_edge_pick #(.LANES(2)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in ({fb_pulse, ref_pulse}),
        .rise_out (rise)
    );

    ljd_err_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_dn),
        .ref_rise (rise[0]),
        .fb_rise  (rise[1]),
        .limit    (limit),
        .verdict  (verdict)
    );

    ljd_lock_track #(.CNT_W(CNT_W), .GOOD_RUN(GOOD_RUN)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_dn      (pwr_dn),
        .verdict     (verdict),
        .thr_acquire (thr_acquire),
        .thr_hold    (thr_hold),
        .limit       (limit),
        .lock_q      (lock_out)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !lock_out); // R9

endmodule

// File: tb/phase_lock_judge_bench.sv
module phase_lock_judge_bench;

    localparam int CNT_W = 8;
    localparam int RUN   = 5;
    localparam int ACQ   = 3;
    localparam int HOLD  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_dn = 1'b0;
    logic             ref_pulse = 1'b0;
    logic             fb_pulse = 1'b0;
    logic [CNT_W-1:0] thr_acquire = CNT_W'(ACQ);
    logic [CNT_W-1:0] thr_hold = CNT_W'(HOLD);
    logic             lock_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  exp_lock = 1'b0;
    int  exp_run  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    phase_lock_judge #(.CNT_W(CNT_W), .GOOD_RUN(RUN)) u_phase_lock_judge (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .thr_acquire(thr_acquire), .thr_hold(thr_hold),
        .lock_out(lock_out)
    );

    task automatic check(input bit got, input bit exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: lock_out=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // reference model: verdict from error against the active limit
    task automatic model(input int err);
        int lim;
        lim = exp_lock ? HOLD : ACQ;
        if (err <= lim) begin
            if (!exp_lock) begin
                exp_run++;
                if (exp_run == RUN) begin
                    exp_lock = 1'b1;
                    exp_run  = 0;
                end
            end
        end else begin
            exp_lock = 1'b0;
            exp_run  = 0;
        end
    endtask

    // one pulse pair with error err; fb_lead picks which edge comes first
    task automatic compare(input int err, input bit fb_lead, input string req);
        for (int i = 0; i <= err; i++) begin
            @(negedge clk);
            ref_pulse = fb_lead ? (i == err) : (i == 0);
            fb_pulse  = fb_lead ? (i == 0)   : (i == err);
        end
        @(negedge clk);
        ref_pulse = 1'b0;
        fb_pulse  = 1'b0;
        repeat (12) @(negedge clk);
        model(err);
        check(lock_out, exp_lock, req);
    endtask

    task automatic power_cycle();
        @(negedge clk);
        pwr_dn = 1'b1;
        repeat (2) @(negedge clk);
        check(lock_out, 1'b0, "R7 held low in power-down");
        pwr_dn = 1'b0;
        exp_lock = 1'b0;
        exp_run  = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lock_out, 1'b0, "R9 reset value");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(lock_out, 1'b0, "R9 after reset release");

        // R1 R2 R4 R5: sweep the lock error and the follow-up error, both orders
        for (int order = 0; order < 2; order++) begin
            for (int d = 0; d <= 8; d++) begin
                power_cycle();
                for (int k = 0; k < RUN; k++)
                    compare(d, order[0], d <= ACQ ? "R2 acquire good" : "R1 R2 acquire bad");
                for (int e = 0; e <= 8; e++) begin
                    if (!exp_lock)
                        for (int k = 0; k < RUN; k++) compare(0, order[0], "R2 relock");
                    compare(e, order[0], e <= HOLD ? "R4 hold keeps lock" : "R5 hold drops lock");
                end
            end
        end

        // R3: a bad comparison mid-run restarts the count
        power_cycle();
        for (int k = 0; k < RUN - 1; k++) compare(ACQ, 1'b0, "R3 partial run");
        compare(ACQ + 1, 1'b0, "R3 bad clears run");
        for (int k = 0; k < RUN - 1; k++) compare(1, 1'b1, "R3 no lock before full run");
        compare(2, 1'b0, "R3 full run locks");

        // R6: missing partner edge judged bad without waiting
        check(lock_out, 1'b1, "R6 locked before missing edge");
        @(negedge clk); ref_pulse = 1'b1;
        @(negedge clk); ref_pulse = 1'b0;
        repeat (10) @(negedge clk);
        check(lock_out, 1'b0, "R6 dropped before partner arrives");
        exp_lock = 1'b0;
        exp_run  = 0;
        @(negedge clk); fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        repeat (12) @(negedge clk);
        check(lock_out, 1'b0, "R6 late edge consumed");
        for (int k = 0; k < RUN; k++) compare(0, 1'b0, "R6 relock after late edge");

        // R7: power-down while locked, then a fresh run is needed
        check(lock_out, 1'b1, "R7 locked before power-down");
        power_cycle();
        for (int k = 0; k < RUN; k++) compare(1, 1'b1, "R7 restart from zero");

        // R8: idle time leaves the flag unchanged
        repeat (40) @(negedge clk);
        check(lock_out, exp_lock, "R8 stable while idle");

        finished = 1'b1;
        summary();
    end

endmodule